// File: doc/BRIEF.md
# Dual-Mode 16x Baud Tick Generator

This block derives the 16x oversampling strobe that a UART transmitter and receiver share. It runs from a fixed peripheral clock and is set by a 16-bit reload value, a mode pin and a run pin. The mode pin chooses between two generators.

- **Integer divider.** A down-counter reloads from the value and strobes once per reload period. The value is set to f_clk / (16 x baud). This mode suits slow rates such as 9600 baud.
- **Fractional accumulator.** The value is added to a 16-bit phase register on every clock, and the carry out of that sum is the strobe. The value is set to (baud x 16 x 65536) / f_clk. This mode suits rates of 19200 baud and above, where an integer divide would leave a large rate error.

Software clears the run pin before it changes the value or the mode, then sets it again. Starting the generator reloads the counter and clears the phase register, so the first strobe comes one full period after the start.

The strobe is a registered one-cycle pulse. It is not a stream, so the block has no handshake: every pin is a plain level.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, tick_o is 0.
- R2: While run_i is 0, no strobe is produced. tick_o is 0 on the clock after any edge that samples run_i low.
- R3: With frac_mode_i = 0 (divider) and a reload value N >= 2, tick_o pulses once every N clocks.
- R4: With frac_mode_i = 1 (accumulator), tick_o is the carry out of a 16-bit phase register that adds reload_i on every clock. The average rate is reload_i / 65536 strobes per clock.
- R5: The edge that first samples run_i = 1 loads the counter with reload_i and clears the phase register. The clock after that edge has no strobe.
  - Divider: the first pulse is visible N edges after the start edge.
  - Accumulator with 0x8000: the first pulse is visible 2 edges after the start edge.
- R6: In divider mode, a reload value of 0 or 1 gives a strobe on every running clock after the start edge.
- R7: The strobe lasts one clock when the divider reload is >= 2 or the accumulator reload is <= 0x8000.
- R8: reload_i and frac_mode_i are held stable while running. A stop and restart takes up a new value, with the timing given in R5.
- R9: tick_o is registered. The pulse appears on the edge after the one where the counter reaches 1 or the sum carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_i | input | 16 | Divider reload or accumulator increment |
| frac_mode_i | input | 1 | 1 selects the accumulator, 0 selects the divider |
| run_i | input | 1 | Run enable; 0 stops the generator |
| tick_o | output | 1 | Registered 16x strobe, one clock wide |

## Verification
The bench measures the strobe rate over long windows in both modes, including extreme accumulator increments and the degenerate divider values 0 and 1. An off-by-one reload, or a carry taken from the wrong bit, would move those counts by far more than one.

Directed checks pin down the exact cycle of the first strobe after a start, which catches a generator that fails to reload or clear on start and so fires early. They also check that the strobe drops at once when stopped, and that a restart picks up a new reload value rather than a stale count.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    GEN_DIV = 1'b0,
    GEN_ACC = 1'b1
  } gen_mode_e;

  localparam int DEF_RELOAD_W = 16;
endpackage

// File: rtl/baud_div_core.sv
module baud_div_core #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                start_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                fire_o
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                wrap;

  // a count of 0 or 1 wraps, so a reload of 0 or 1 never underflows
  assign wrap   = (cnt_q < RELOAD_W'(2));
  assign fire_o = en_i & ~start_i & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (start_i || wrap) cnt_q <= reload_i;
      else                 cnt_q <= cnt_q - RELOAD_W'(1);
    end
  end

  AST_DIV_SMALL_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && reload_i < RELOAD_W'(2)) |-> fire_o); // R6
endmodule

// File: rtl/baud_acc_core.sv
module baud_acc_core #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                start_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                fire_o
);
  logic [RELOAD_W-1:0] phase_q;
  logic [RELOAD_W:0]   sum;

  assign sum    = {1'b0, phase_q} + {1'b0, reload_i};
  assign fire_o = en_i & ~start_i & sum[RELOAD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (en_i) begin
      if (start_i) phase_q <= '0;
      else         phase_q <= sum[RELOAD_W-1:0];
    end
  end

  AST_ACC_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && reload_i <= {1'b1, {(RELOAD_W-1){1'b0}}}) |=> !fire_o); // R7
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RELOAD_W = baud_pkg::DEF_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                frac_mode_i,
  input  logic                run_i,
  output logic                tick_o
);
  import baud_pkg::*;

  gen_mode_e mode;
  logic      run_q;
  logic      start;
  logic      div_en;
  logic      acc_en;
  logic      div_fire;
  logic      acc_fire;
  logic      fire;

  assign mode   = gen_mode_e'(frac_mode_i);
  assign start  = run_i & ~run_q;
  assign div_en = run_i & (mode == GEN_DIV);
  assign acc_en = run_i & (mode == GEN_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_i;
  end

  baud_div_core #(.RELOAD_W(RELOAD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(div_en), .start_i(start),
    .reload_i(reload_i), .fire_o(div_fire)
  );

  baud_acc_core #(.RELOAD_W(RELOAD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en_i(acc_en), .start_i(start),
    .reload_i(reload_i), .fire_o(acc_fire)
  );

  assign fire = (mode == GEN_ACC) ? acc_fire : div_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_o <= 1'b0;
    else        tick_o <= fire;
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RST_QUIET: assert (!tick_o); // R1
  end

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_o); // R2

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !tick_o); // R5

  AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_i && mode == GEN_DIV && reload_i > RELOAD_W'(1)) |=> !tick_o); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && run_q) |-> ($stable(reload_i) && $stable(frac_mode_i))); // R8
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reload = 16'd0;
  logic        frac = 1'b0;
  logic        run = 1'b0;
  logic        tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reload_i(reload),
    .frac_mode_i(frac), .run_i(run), .tick_o(tick)
  );

  // {mode, reload, window}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'd5,      16'd1000},  // R3
    {1'b0, 16'd16,     16'd2000},  // R3
    {1'b0, 16'd651,    16'd20000}, // R3
    {1'b0, 16'd1,      16'd200},   // R6
    {1'b0, 16'd0,      16'd200},   // R6
    {1'b1, 16'h8000,   16'd1000},  // R4
    {1'b1, 16'h2000,   16'd4000},  // R4
    {1'b1, 16'h0400,   16'd8192},  // R4
    {1'b1, 16'hFFFF,   16'd1000},  // R4
    {1'b1, 16'h0001,   16'd60000}  // R4
  };

  task automatic check(input string req, input int act, input int exp, input int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // stop, load config, restart; returns at the negedge where run rises
  task automatic restart(input logic m, input logic [15:0] r);
    @(negedge clk); run = 1'b0;
    @(negedge clk); frac = m; reload = r;
    @(negedge clk); run = 1'b1;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int c;
    // R1: quiet through reset
    repeat (3) @(negedge clk);
    check("R1", int'(tick), 0, 0);
    rst_n = 1'b1;

    // table walk: strobe rate in both modes
    for (int i = 0; i < NV; i++) begin
      int w;
      int exp;
      w = int'(VEC[i][15:0]);
      if (VEC[i][32]) exp = int'((longint'(w) * longint'(VEC[i][31:16])) >>> 16);
      else            exp = w / ((VEC[i][31:16] < 2) ? 1 : int'(VEC[i][31:16]));
      restart(VEC[i][32], VEC[i][31:16]);
      c = 0;
      for (int k = 0; k < w; k++) begin
        @(negedge clk);
        c += int'(tick);
      end
      check(VEC[i][32] ? "R4 rate" : "R3/R6 rate", c, exp, 1);
    end

    // R5/R9/R7: divider N=5, pulse after edge 5 following the start edge
    restart(1'b0, 16'd5);
    c = 0;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (k == 5)  check("R5 div first", int'(tick), 0, 0);
      if (k == 6)  check("R9 div pulse", int'(tick), 1, 0);
      if (k == 7)  check("R7 div width", int'(tick), 0, 0);
      if (k == 11) check("R3 div second", int'(tick), 1, 0);
    end

    // R2: stop drops the strobe at once and keeps it low
    restart(1'b0, 16'd1);
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check("R2 stop", int'(tick), 0, 0);
    c = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      c += int'(tick);
    end
    check("R2 idle", c, 0, 0);

    // R8: restart takes up a new value (3)
    restart(1'b0, 16'd3);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) check("R8 new reload early", int'(tick), 0, 0);
      if (k == 4) check("R8 new reload pulse", int'(tick), 1, 0);
    end

    // R4/R5: accumulator 0x8000 from cleared phase
    restart(1'b1, 16'h8000);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 2) check("R5 acc first", int'(tick), 0, 0);
      if (k == 3) check("R4 acc carry", int'(tick), 1, 0);
      if (k == 4) check("R7 acc width", int'(tick), 0, 0);
      if (k == 5) check("R4 acc carry2", int'(tick), 1, 0);
    end

    // R6: reload 0 strobes on every clock after the start edge
    restart(1'b0, 16'd0);
    @(negedge clk);
    check("R6 start quiet", int'(tick), 0, 0);
    c = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      c += int'(tick);
    end
    check("R6 every clock", c, 4, 0);

    @(negedge clk); run = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule